// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block is the programming front end of a dual-synthesizer transceiver. A host shifts 24-bit command words in over three lines: a serial clock, a data line and a latch line. Each word names one of eight shadow registers in its three low bits, and the rest of the word is written into that register only when a latch pulse follows the last data bit. The serial lines are oversampled by the system clock through a synchronizer. The host may toggle them at any rate well below the system clock.

From the stored words the block drives one set of synthesizer controls: the main and reference division ratios, the prescaler code, the phase-detector polarity, the charge-pump current and tristate, and the two power enables. A power-control pin selects whether the receive settings or the transmit settings are presented, so the radio can switch direction without any bus traffic. The block also builds a single lock indication for the baseband. It takes the lock of the receive or the transmit synthesizer, as chosen by a stored bit, applies an optional inversion, and gates the result with an external synthesizer's lock input. Analog bias, gain and filter fields are only stored and passed out unchanged.

Top module: `syn_ctrl_regbank`

## Requirements
- R1: While reset is asserted, and after it is released until a word is committed, every output is zero except `syn_cp_tri_o`, which is one. In that state both sections are powered down and the charge pump is tristated.
- R2: Serial data is shifted in MSB first on rising edges of `sclk_i`. A rising edge of `slatch_i` commits the last 24 bits shifted. Bits 2:0 give the address (code n selects word n, 0..7) and bits 23:3 are written to that word. No other word changes. The new value reaches the outputs at the third system clock edge after the serial edge is presented.
- R3: Bits shifted without a following latch pulse change no output. When more than 24 bits are shifted before a latch, only the last 24 count.
- R4: The divide ratio is taken from word bits 20:3: word 0 for receive and word 1 for transmit.
- R5: The reference ratio is taken from bits 17:3, the phase-detector polarity from bit 18, and the lock-invert flag from bit 19: word 2 for receive and word 3 for transmit. Word 4 holds the prescaler codes: bits 12:10 for receive and bits 15:13 for transmit.
- R6: Word 4 holds the charge-pump current: bits 4:3 for receive and bits 6:5 for transmit. It also holds a pump-drive bit: bit 7 for receive and bit 8 for transmit. `syn_cp_tri_o` is the inverse of the active section's drive bit.
- R7: `tx_mode_o` follows `pca_i` one system clock edge later. While it is high, the divider, reference, prescaler, polarity and pump outputs show the transmit fields; while it is low, they show the receive fields.
- R8: Word 5 bit 3 enables the receive section and bit 4 enables the transmit section. `rx_pwr_o` is the receive enable while in receive mode and is zero otherwise. `tx_pwr_o` is the transmit enable while in transmit mode and is zero otherwise.
- R9: Word 4 bit 9 selects the lock source: 0 for receive, 1 for transmit. One clock edge after its inputs, `lock_o` equals the selected internal lock, XORed with that section's invert flag, ANDed with `ext_lock_i`.
- R10: `aux_bias_o` carries word 5 bits 23:5. `aux_a_o` and `aux_b_o` carry bits 23:3 of words 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| sdata_i | input | 1 | Serial data, MSB first |
| slatch_i | input | 1 | Commit pulse after the last bit |
| pca_i | input | 1 | Power-control pin: 1 transmit, 0 receive |
| rx_lock_i | input | 1 | Receive synthesizer lock |
| tx_lock_i | input | 1 | Transmit synthesizer lock |
| ext_lock_i | input | 1 | Lock from the external synthesizer |
| tx_mode_o | output | 1 | Registered direction |
| syn_div_o | output | 18 | Active main divide ratio |
| syn_ref_o | output | 15 | Active reference divide ratio |
| syn_psc_o | output | 3 | Active prescaler code |
| syn_pol_o | output | 1 | Active phase-detector polarity |
| syn_cp_o | output | 2 | Active charge-pump current level |
| syn_cp_tri_o | output | 1 | Charge pump tristated |
| rx_pwr_o | output | 1 | Receive section powered |
| tx_pwr_o | output | 1 | Transmit section powered |
| lock_o | output | 1 | Combined lock indication |
| aux_bias_o | output | 19 | Stored analog fields of word 5 |
| aux_a_o | output | 21 | Stored payload of word 6 |
| aux_b_o | output | 21 | Stored payload of word 7 |

## Verification
The hardest condition to reach from the ports is a shift register that holds a complete, valid-looking word while no commit has happened. It is just as hard to reach one that holds more bits than a word, so that only the last 24 may land. The stimulus shifts a full word to address 0 and then holds the latch low for many cycles. Later it shifts four extra bits ahead of a word before latching. A behavioural model replays the synchronizer delay from a history of sampled pins and is compared with every output on every cycle. Flipping the power-control pin with the transmit and receive fields set to different values checks that the output mux and the lock select stay independent.

// File: rtl/syn_ctrl_pkg.sv
package syn_ctrl_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned NUM_WORDS = 1 << ADDR_W;
  localparam int unsigned PAY_W     = WORD_W - ADDR_W;
  localparam int unsigned DIV_W     = 18;
  localparam int unsigned REF_W     = 15;
  localparam int unsigned CP_W      = 2;
  localparam int unsigned PSC_W     = 3;
  // payload bit positions (payload bit n = word bit n + ADDR_W)
  localparam int unsigned P_POL     = REF_W;
  localparam int unsigned P_INV     = REF_W + 1;
  localparam int unsigned P_RXCP    = 0;
  localparam int unsigned P_TXCP    = P_RXCP + CP_W;
  localparam int unsigned P_RXDRV   = P_TXCP + CP_W;
  localparam int unsigned P_TXDRV   = P_RXDRV + 1;
  localparam int unsigned P_LSEL    = P_TXDRV + 1;
  localparam int unsigned P_RXPSC   = P_LSEL + 1;
  localparam int unsigned P_TXPSC   = P_RXPSC + PSC_W;
  localparam int unsigned P_RXEN    = 0;
  localparam int unsigned P_TXEN    = 1;
  localparam int unsigned P_AUX5    = 2;
  localparam int unsigned AUX5_W    = PAY_W - P_AUX5;

  typedef enum logic [ADDR_W-1:0] {
    W_RXDIV = 3'd0, W_TXDIV = 3'd1, W_RXREF = 3'd2, W_TXREF = 3'd3,
    W_PUMP  = 3'd4, W_POWER = 3'd5, W_AUXA  = 3'd6, W_AUXB  = 3'd7
  } waddr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [REF_W-1:0] refdiv;
    logic             pol;
    logic             lk_inv;
    logic [CP_W-1:0]  cp;
    logic             drive;
    logic [PSC_W-1:0] psc;
    logic             en;
  } synth_cfg_t;
endpackage

// File: rtl/syn_ser_rx.sv
module syn_ser_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WORD_W      = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              slatch_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int unsigned LINES = 3; // {latch, data, clock}

  logic [SYNC_STAGES-1:0][LINES-1:0] sync_q;
  logic [LINES-1:0]                  prev_q;
  logic [LINES-1:0]                  tail;
  logic [WORD_W-1:0]                 shift_q, shift_d;
  logic                              shift_en, lat_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= {slatch_i, sdata_i, sclk_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    tail     = sync_q[SYNC_STAGES-1];
    shift_en = tail[0] & ~prev_q[0];
    lat_rise = tail[2] & ~prev_q[2];
    shift_d  = {shift_q[WORD_W-2:0], tail[1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  assign word_o   = shift_q;
  assign commit_o = lat_rise;
endmodule

// File: rtl/syn_shadow_bank.sv
module syn_shadow_bank #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PAY_W  = 21,
  localparam int unsigned NUM   = 1 << ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [PAY_W-1:0]          data_i,
  output logic [NUM-1:0][PAY_W-1:0] regs_o,
  output logic [NUM-1:0]            we_o
);
  always_comb begin
    for (int i = 0; i < NUM; i++) we_o[i] = commit_i && (addr_i == ADDR_W'(i));
  end

  for (genvar g = 0; g < NUM; g++) begin : g_word
    logic [PAY_W-1:0] val_q, val_d;
    assign val_d = we_o[g] ? data_i : val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '0;
      else         val_q <= val_d;
    end
    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/syn_lock_comb.sv
module syn_lock_comb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_lock_i,
  input  logic tx_lock_i,
  input  logic ext_lock_i,
  input  logic rx_inv_i,
  input  logic tx_inv_i,
  input  logic sel_tx_i,
  output logic lock_o
);
  logic int_lock, lock_d, lock_q;

  always_comb begin
    int_lock = sel_tx_i ? (tx_lock_i ^ tx_inv_i) : (rx_lock_i ^ rx_inv_i);
    lock_d   = int_lock & ext_lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_d;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/syn_ctrl_regbank.sv
module syn_ctrl_regbank
  import syn_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              slatch_i,
  input  logic              pca_i,
  input  logic              rx_lock_i,
  input  logic              tx_lock_i,
  input  logic              ext_lock_i,
  output logic              tx_mode_o,
  output logic [DIV_W-1:0]  syn_div_o,
  output logic [REF_W-1:0]  syn_ref_o,
  output logic [PSC_W-1:0]  syn_psc_o,
  output logic              syn_pol_o,
  output logic [CP_W-1:0]   syn_cp_o,
  output logic              syn_cp_tri_o,
  output logic              rx_pwr_o,
  output logic              tx_pwr_o,
  output logic              lock_o,
  output logic [AUX5_W-1:0] aux_bias_o,
  output logic [PAY_W-1:0]  aux_a_o,
  output logic [PAY_W-1:0]  aux_b_o
);
  logic [WORD_W-1:0]                 word_s;
  logic                              commit_s;
  logic [NUM_WORDS-1:0][PAY_W-1:0]   regs_s;
  logic [NUM_WORDS-1:0]              we_s;
  logic                              mode_q, mode_d;
  synth_cfg_t                        rx_cfg, tx_cfg, act_cfg;
  logic [PAY_W-1:0]                  w_pump;
  logic                              lock_sel_tx;
  logic                              unused_bits;

  // R2 serial capture
  syn_ser_rx #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(WORD_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .slatch_i(slatch_i), .word_o(word_s), .commit_o(commit_s)
  );

  syn_shadow_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit_s),
    .addr_i(word_s[ADDR_W-1:0]), .data_i(word_s[WORD_W-1:ADDR_W]),
    .regs_o(regs_s), .we_o(we_s)
  );

  // R7 direction register
  assign mode_d = pca_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end

  assign w_pump = regs_s[W_PUMP];

  always_comb begin
    rx_cfg.div    = regs_s[W_RXDIV][DIV_W-1:0];
    rx_cfg.refdiv = regs_s[W_RXREF][REF_W-1:0];
    rx_cfg.pol    = regs_s[W_RXREF][P_POL];
    rx_cfg.lk_inv = regs_s[W_RXREF][P_INV];
    rx_cfg.cp     = w_pump[P_RXCP +: CP_W];
    rx_cfg.drive  = w_pump[P_RXDRV];
    rx_cfg.psc    = w_pump[P_RXPSC +: PSC_W];
    rx_cfg.en     = regs_s[W_POWER][P_RXEN];

    tx_cfg.div    = regs_s[W_TXDIV][DIV_W-1:0];
    tx_cfg.refdiv = regs_s[W_TXREF][REF_W-1:0];
    tx_cfg.pol    = regs_s[W_TXREF][P_POL];
    tx_cfg.lk_inv = regs_s[W_TXREF][P_INV];
    tx_cfg.cp     = w_pump[P_TXCP +: CP_W];
    tx_cfg.drive  = w_pump[P_TXDRV];
    tx_cfg.psc    = w_pump[P_TXPSC +: PSC_W];
    tx_cfg.en     = regs_s[W_POWER][P_TXEN];

    act_cfg = mode_q ? tx_cfg : rx_cfg;
  end

  assign lock_sel_tx = w_pump[P_LSEL];

  // R9 combined lock
  syn_lock_comb u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_lock_i(rx_lock_i), .tx_lock_i(tx_lock_i),
    .ext_lock_i(ext_lock_i), .rx_inv_i(rx_cfg.lk_inv), .tx_inv_i(tx_cfg.lk_inv),
    .sel_tx_i(lock_sel_tx), .lock_o(lock_o)
  );

  assign tx_mode_o    = mode_q;
  assign syn_div_o    = act_cfg.div;
  assign syn_ref_o    = act_cfg.refdiv;
  assign syn_psc_o    = act_cfg.psc;
  assign syn_pol_o    = act_cfg.pol;
  assign syn_cp_o     = act_cfg.cp;
  assign syn_cp_tri_o = ~act_cfg.drive;
  assign rx_pwr_o     = rx_cfg.en & ~mode_q;
  assign tx_pwr_o     = tx_cfg.en & mode_q;
  assign aux_bias_o   = regs_s[W_POWER][PAY_W-1:P_AUX5];
  assign aux_a_o      = regs_s[W_AUXA];
  assign aux_b_o      = regs_s[W_AUXB];

  assign unused_bits = ^{regs_s[W_RXDIV][PAY_W-1:DIV_W], regs_s[W_TXDIV][PAY_W-1:DIV_W],
                         regs_s[W_RXREF][PAY_W-1:P_INV+1], regs_s[W_TXREF][PAY_W-1:P_INV+1],
                         w_pump[PAY_W-1:P_TXPSC+PSC_W], act_cfg.lk_inv, act_cfg.en};
endmodule

// File: rtl/syn_ctrl_chk.sv
module syn_ctrl_chk #(
  parameter int unsigned NUM   = 8,
  parameter int unsigned PAY_W = 21
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pca_i,
  input logic             ext_lock_i,
  input logic             tx_mode_o,
  input logic             lock_o,
  input logic             syn_cp_tri_o,
  input logic             rx_pwr_o,
  input logic             tx_pwr_o,
  input logic [PAY_W-1:0] aux_a_o,
  input logic             commit_i,
  input logic [NUM-1:0]   we_i
);
  AST_ONE_WORD_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(we_i)); // R2
  AST_HOLD_WITHOUT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) !commit_i |=> $stable(aux_a_o)); // R3
  AST_MODE_TRACKS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (tx_mode_o == $past(pca_i))); // R7
  AST_POWER_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(rx_pwr_o && tx_pwr_o)); // R8
  AST_LOCK_NEEDS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (!lock_o || $past(ext_lock_i))); // R9
  AST_PUMP_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(syn_cp_tri_o) |-> ($past(commit_i) || !$stable(tx_mode_o))); // R6
endmodule

bind syn_ctrl_regbank syn_ctrl_chk #(.NUM(syn_ctrl_pkg::NUM_WORDS), .PAY_W(syn_ctrl_pkg::PAY_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pca_i(pca_i), .ext_lock_i(ext_lock_i),
  .tx_mode_o(tx_mode_o), .lock_o(lock_o), .syn_cp_tri_o(syn_cp_tri_o),
  .rx_pwr_o(rx_pwr_o), .tx_pwr_o(tx_pwr_o), .aux_a_o(aux_a_o),
  .commit_i(commit_s), .we_i(we_s)
);

// File: tb/syn_ctrl_regbank_tb_top.sv
`timescale 1ns/1ps
module syn_ctrl_regbank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, slatch = 1'b0, pca = 1'b0;
  logic rxl = 1'b0, txl = 1'b0, extl = 1'b0;
  logic tx_mode, pol, cp_tri, rx_pwr, tx_pwr, lock;
  logic [17:0] div; logic [14:0] refd; logic [2:0] psc; logic [1:0] cp;
  logic [18:0] aux5; logic [20:0] auxa, auxb;
  int total = 0, fails = 0;
  bit done = 0, armed = 0;

  always #4 clk = ~clk;

  syn_ctrl_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .slatch_i(slatch),
    .pca_i(pca), .rx_lock_i(rxl), .tx_lock_i(txl), .ext_lock_i(extl),
    .tx_mode_o(tx_mode), .syn_div_o(div), .syn_ref_o(refd), .syn_psc_o(psc),
    .syn_pol_o(pol), .syn_cp_o(cp), .syn_cp_tri_o(cp_tri), .rx_pwr_o(rx_pwr),
    .tx_pwr_o(tx_pwr), .lock_o(lock), .aux_bias_o(aux5), .aux_a_o(auxa), .aux_b_o(auxb)
  );

  // behavioural reference: sampled-pin history and eight stored words
  bit qc[$], qd[$], ql[$];
  logic [23:0] m_sh;
  logic [20:0] m_reg [8];
  logic m_mode, m_lock;

  function automatic logic model_lock();
    logic il;
    il = m_reg[4][6] ? (txl ^ m_reg[3][16]) : (rxl ^ m_reg[2][16]);
    return il & extl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qc = '{0, 0, 0, 0}; qd = '{0, 0, 0, 0}; ql = '{0, 0, 0, 0};
      m_sh = '0; m_mode = 0; m_lock = 0;
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
    end else begin
      m_lock = model_lock();
      m_mode = pca;
      qc.push_front(sclk); void'(qc.pop_back());
      qd.push_front(sdata); void'(qd.pop_back());
      ql.push_front(slatch); void'(ql.pop_back());
      if (ql[2] && !ql[3]) m_reg[m_sh[2:0]] = m_sh[23:3];
      if (qc[2] && !qc[3]) m_sh = {m_sh[22:0], qd[2]};
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [20:0] rf, pm, pw;
    rf = m_mode ? m_reg[3] : m_reg[2];
    pm = m_reg[4];
    pw = m_reg[5];
    chk("R7", "mode", 32'(tx_mode), 32'(m_mode));
    chk("R4", "div", 32'(div), 32'(m_mode ? m_reg[1][17:0] : m_reg[0][17:0]));
    chk("R5", "ref", 32'(refd), 32'(rf[14:0]));
    chk("R5", "pol", 32'(pol), 32'(rf[15]));
    chk("R5", "psc", 32'(psc), 32'(m_mode ? pm[12:10] : pm[9:7]));
    chk("R6", "cp", 32'(cp), 32'(m_mode ? pm[3:2] : pm[1:0]));
    chk("R6", "tri", 32'(cp_tri), 32'(m_mode ? !pm[5] : !pm[4]));
    chk("R8", "rxpwr", 32'(rx_pwr), 32'(pw[0] & !m_mode));
    chk("R8", "txpwr", 32'(tx_pwr), 32'(pw[1] & m_mode));
    chk("R9", "lock", 32'(lock), 32'(m_lock));
    chk("R10", "aux5", 32'(aux5), 32'(pw[20:2]));
    chk("R10", "auxa", 32'(auxa), 32'(m_reg[6]));
    chk("R10", "auxb", 32'(auxb), 32'(m_reg[7]));
  endtask

  always @(negedge clk) if (armed && !done) compare_model();

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    repeat (3) @(negedge clk);
    slatch = 1'b1;
    repeat (3) @(negedge clk);
    slatch = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_word(input logic [2:0] a, input logic [20:0] p);
    send_bits({8'h00, p, a}, 24);
    pulse_latch();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    armed = 1;
    // R1 reset state
    chk("R1", "rst tri", 32'(cp_tri), 32'd1);
    chk("R1", "rst div", 32'(div), 32'd0);
    chk("R1", "rst pwr", 32'({rx_pwr, tx_pwr, lock, tx_mode}), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "post-rst tri", 32'(cp_tri), 32'd1);

    // R2 / R4 / R5 / R6 / R8 programming
    write_word(3'd0, 21'h02AAAA);
    chk("R4", "rx div", 32'(div), 32'h2AAAA);
    write_word(3'd1, 21'h015555);
    chk("R2", "rx div kept", 32'(div), 32'h2AAAA);
    write_word(3'd2, 21'h009234);
    write_word(3'd3, 21'h017FFF);
    write_word(3'd4, 21'h000AD6);
    write_word(3'd5, {19'h5A5A5, 2'b11});
    chk("R5", "rx ref", 32'(refd), 32'h1234);
    chk("R5", "rx pol", 32'(pol), 32'd1);
    chk("R5", "rx psc", 32'(psc), 32'd5);
    chk("R6", "rx cp", 32'(cp), 32'd2);
    chk("R6", "rx tri", 32'(cp_tri), 32'd0);
    chk("R8", "rx pwr", 32'({rx_pwr, tx_pwr}), 32'b10);
    chk("R10", "aux5", 32'(aux5), 32'h5A5A5);

    // R7 switch to transmit
    pca = 1'b1;
    @(negedge clk);
    chk("R7", "mode 1 edge", 32'(tx_mode), 32'd1);
    chk("R7", "tx div", 32'(div), 32'h15555);
    chk("R5", "tx ref", 32'(refd), 32'h7FFF);
    chk("R6", "tx tri", 32'(cp_tri), 32'd1);
    chk("R8", "tx pwr", 32'({rx_pwr, tx_pwr}), 32'b01);

    // R9 lock: transmit source, inverted
    extl = 1'b1; txl = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "tx inv lock", 32'(lock), 32'd1);
    txl = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "tx locked inv", 32'(lock), 32'd0);
    txl = 1'b0; extl = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "ext gate", 32'(lock), 32'd0);
    pca = 1'b0;
    write_word(3'd4, 21'h000A96); // lock source receive
    rxl = 1'b1; extl = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "rx lock", 32'(lock), 32'd1);
    rxl = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "rx unlock", 32'(lock), 32'd0);

    // R3 shifting without a latch
    send_bits({8'h00, 21'h000001, 3'd0}, 24);
    repeat (40) @(negedge clk);
    chk("R3", "no latch", 32'(div), 32'h2AAAA);
    send_bits(32'hF, 4);
    write_word(3'd0, 21'h030F0F);
    chk("R3", "last 24 bits", 32'(div), 32'h30F0F);

    // R10 auxiliary words, R2 isolation
    write_word(3'd6, 21'h1ABCDE);
    write_word(3'd7, 21'h054321);
    chk("R10", "aux a", 32'(auxa), 32'h1ABCDE);
    chk("R10", "aux b", 32'(auxb), 32'h054321);
    chk("R2", "word0 intact", 32'(div), 32'h30F0F);
    pca = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "word1 intact", 32'(div), 32'h15555);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule